// File: doc/BRIEF.md
# Peripheral-Shared Parallel I/O Port

This block is a bidirectional parallel port of configurable width (16 pins by default). Software programs it through a small write/read register interface. Each pin works either as general-purpose I/O or as a pin handed over to an on-chip peripheral. The block produces, for every pin, a drive value and an output enable for the pad. It also routes signals between the pins and the peripheral side, which is modelled as plain input and output vectors.

There are four control registers. The assignment register picks between GPIO and peripheral use. The direction register sets output or input. The open-drain register selects pull-low-only drive. The data register holds the output latch.

Two pins are wired to fixed serial-channel roles. The receive pin (bit 0 by default) is always an input when assigned, and it is the only pin that cannot be open-drain. The transmit pin (bit 1 by default) is always an output when assigned. On every other pin, the direction bit chooses whether an assigned pin carries a peripheral output or a peripheral input.

A peripheral whose pin is not assigned sees logic 0 on its input, and its output never reaches the pin. Pin levels pass through a two-flop synchronizer before software or a peripheral sees them.

Top module: `pio_port`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0 and no output enable is active.
- R2: Register addresses are 0 = assignment, 1 = direction, 2 = open-drain, 3 = data. A write always updates the addressed register, including the data latch on input pins. A data read returns the latch bit for pins with direction 1 and the synchronized pin level for pins with direction 0.
- R3: A GPIO pin (assignment 0) with direction 1 and push-pull drive has its output enable active and drives its data latch bit.
- R4: A change on a pin input shows in the data register readback after exactly two rising clock edges, and not after one.
- R5: When assigned, the receive pin is never driven, and its peripheral input follows the synchronized pin level. When not assigned, that peripheral input is held at 0.
- R6: When assigned, the transmit pin drives the peripheral output with its enable active, whatever its direction bit. When not assigned, the peripheral output has no effect on the pin's value or enable.
- R7: A pin with open-drain selected enables its driver only while the value it would drive is 0, and it then drives 0.
- R8: The receive pin has no open-drain capability: its open-drain bit reads 0 after a write of 1 and does not alter its drive.
- R9: Any other assigned pin drives its peripheral output when its direction bit is 1. When its direction bit is 0, it passes its synchronized level to its peripheral input. Peripheral inputs of unassigned pins are 0.
- R10: Open-drain drive applies to GPIO output pins as well as peripheral output pins, including the transmit pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for the selected register |
| pin_in | input | WIDTH | Pad input levels |
| pin_out | output | WIDTH | Pad drive values |
| pin_oe | output | WIDTH | Pad output enables |
| per_out | input | WIDTH | Values the peripherals want to drive (transmit at TX_BIT) |
| per_in | output | WIDTH | Signals delivered to the peripherals (receive at RX_BIT) |

## Verification
The bench builds the block with its defaults: WIDTH 16, receive at bit 0, transmit at bit 1, and open-drain on every pin except bit 0. With these values, one register write pattern reaches both fixed-role pins and fourteen direction-selected pins side by side. Mixed assignment, direction and open-drain words therefore exercise all routing cases in each vector. Directed steps cover the two-edge synchronizer latency, the hardwired open-drain bit, and the reset state.

// File: rtl/pio_pkg.sv
// Package: shared register address encoding for the parallel port.
// Assumes a 2-bit register select on the write/read interface.
package pio_pkg;

    typedef enum logic [1:0] {
        REG_ASSIGN = 2'd0,
        REG_DIR    = 2'd1,
        REG_OD     = 2'd2,
        REG_DATA   = 2'd3
    } pio_reg_e;

endpackage

// File: rtl/pio_sync.sv
// Module: pio_sync
// Two-flop synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module pio_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;

    // Two register stages toward the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2))); // R4

endmodule

// File: rtl/pio_regs.sv
// Module: pio_regs
// Control register file: assignment, direction, open-drain, data latch.
// Assumes single-cycle writes and a combinational read of the selected register.
// Open-drain bits outside OD_MASK are hardwired to 0.
module pio_regs
    import pio_pkg::*;
#(
    parameter int               WIDTH   = 16,
    parameter logic [WIDTH-1:0] OD_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] bus_rdata,
    output logic [WIDTH-1:0] asg_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] od_q,
    output logic [WIDTH-1:0] dat_q
);

    pio_reg_e sel;
    assign sel = pio_reg_e'(bus_addr);

    // Register updates on write strobe; all clear in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asg_q <= '0;
            dir_q <= '0;
            od_q  <= '0;
            dat_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                REG_ASSIGN: asg_q <= bus_wdata;
                REG_DIR:    dir_q <= bus_wdata;
                REG_OD:     od_q  <= bus_wdata & OD_MASK;
                REG_DATA:   dat_q <= bus_wdata;
                default:    ;
            endcase
        end
    end

    // Read multiplexer; data reads mix latch and sampled pin by direction.
    always_comb begin
        case (sel)
            REG_ASSIGN: bus_rdata = asg_q;
            REG_DIR:    bus_rdata = dir_q;
            REG_OD:     bus_rdata = od_q;
            REG_DATA:   bus_rdata = (dat_q & dir_q) | (pin_sync & ~dir_q);
            default:    bus_rdata = '0;
        endcase
    end

    AST_OD_UNCAPABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (od_q & ~OD_MASK) == '0); // R8

endmodule

// File: rtl/pio_pin_cell.sv
// Module: pio_pin_cell
// One pin: selects GPIO or peripheral routing, applies open-drain drive,
// and gates the peripheral input. ROLE picks a fixed receive, fixed
// transmit, or direction-selected function. Purely combinational.
module pio_pin_cell #(
    parameter int ROLE   = 0,   // 0: direction-selected, 1: fixed receive, 2: fixed transmit
    parameter bit OD_OK  = 1'b1
) (
    input  logic asg,
    input  logic dir,
    input  logic od,
    input  logic dat,
    input  logic pin_s,
    input  logic per_val,
    output logic drv_val,
    output logic drv_oe,
    output logic per_rx
);

    localparam int ROLE_ANY = 0;
    localparam int ROLE_RX  = 1;
    localparam int ROLE_TX  = 2;

    logic role_out;
    logic base_oe;
    logic raw_val;
    logic od_on;

    // Decide whether the assigned function of this pin is an output.
    generate
        if (ROLE == ROLE_RX) begin : g_rx
            assign role_out = 1'b0;
        end else if (ROLE == ROLE_TX) begin : g_tx
            assign role_out = 1'b1;
        end else begin : g_any
            assign role_out = dir;
        end
    endgenerate

    // Open-drain only where the pin supports it.
    generate
        if (OD_OK) begin : g_od
            assign od_on = od;
        end else begin : g_pp
            assign od_on = 1'b0;
        end
    endgenerate

    // Source select, drive enable and peripheral input gating.
    always_comb begin
        base_oe = asg ? role_out : dir;
        raw_val = asg ? (role_out & per_val) : dat;
        drv_val = od_on ? 1'b0 : raw_val;
        drv_oe  = base_oe & (od_on ? ~raw_val : 1'b1);
        per_rx  = (asg & ~role_out) ? pin_s : 1'b0;
    end

endmodule

// File: rtl/pio_port.sv
// Module: pio_port
// Top of the peripheral-shared parallel port: register file, input
// synchronizer and one routing cell per pin. RX_BIT and TX_BIT name the
// pins with fixed serial-channel roles; OD_MASK lists open-drain capable pins.
// Assumes pads and peripherals are modelled as plain vectors.
module pio_port
    import pio_pkg::*;
#(
    parameter int               WIDTH   = 16,
    parameter int               RX_BIT  = 0,
    parameter int               TX_BIT  = 1,
    parameter logic [WIDTH-1:0] OD_MASK = {WIDTH{1'b1}} & ~(WIDTH'(1) << RX_BIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    input  logic [WIDTH-1:0] per_out,
    output logic [WIDTH-1:0] per_in
);

    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] asg_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] od_q;
    logic [WIDTH-1:0] dat_q;

    pio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    pio_regs #(.WIDTH(WIDTH), .OD_MASK(OD_MASK)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata),
        .asg_q     (asg_q),
        .dir_q     (dir_q),
        .od_q      (od_q),
        .dat_q     (dat_q)
    );

    // One routing cell per pin, role fixed by its position.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            localparam int CELL_ROLE = (i == RX_BIT) ? 1 : ((i == TX_BIT) ? 2 : 0);
            pio_pin_cell #(.ROLE(CELL_ROLE), .OD_OK(OD_MASK[i])) u_cell (
                .asg     (asg_q[i]),
                .dir     (dir_q[i]),
                .od      (od_q[i]),
                .dat     (dat_q[i]),
                .pin_s   (pin_sync[i]),
                .per_val (per_out[i]),
                .drv_val (pin_out[i]),
                .drv_oe  (pin_oe[i]),
                .per_rx  (per_in[i])
            );
        end
    endgenerate

    AST_RX_UNASSIGNED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !asg_q[RX_BIT] |-> !per_in[RX_BIT]); // R5
    AST_RX_NEVER_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        asg_q[RX_BIT] |-> !pin_oe[RX_BIT]); // R5
    AST_TX_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!asg_q[TX_BIT] && pin_oe[TX_BIT]) |-> (pin_out[TX_BIT] == dat_q[TX_BIT])); // R6
    AST_OD_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((od_q & pin_oe & pin_out) == '0)); // R7
    AST_GPIO_OUT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (((~asg_q) & dir_q & ~od_q & ~pin_oe) == '0)); // R3

endmodule

// File: tb/pio_port_bench.sv
module pio_port_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;
    logic [W-1:0] per_out = '0;
    logic [W-1:0] per_in;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pio_port u_pio_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .per_out(per_out), .per_in(per_in)
    );

    // Stimulus: assignment, direction, open-drain, data, pin level, peripheral out.
    typedef logic [W-1:0] vec6_t [6];
    localparam int NV = 10;
    localparam logic [6*W-1:0] VECS [NV] = '{
        {16'h0000, 16'hFFFF, 16'h0000, 16'hA5C3, 16'h0000, 16'h0000},
        {16'h0000, 16'h0000, 16'h0000, 16'h1234, 16'h5A5A, 16'hFFFF},
        {16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'h1111, 16'hC3A5},
        {16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 16'hF0F1, 16'hFFFF},
        {16'h0000, 16'hFFFF, 16'hFFFF, 16'h0F0F, 16'h0000, 16'h0000},
        {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'h55AA},
        {16'h00F3, 16'h0F0F, 16'h0302, 16'h9C36, 16'hA5A5, 16'h3C3D},
        {16'h0003, 16'h0000, 16'h0002, 16'h0000, 16'h0001, 16'h0000},
        {16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF},
        {16'h0002, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0002}
    };

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [W-1:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            pin_in = '0;
            rd(a[1:0], r);
            check("R1 register reset", r, '0);
        end
        check("R1 no enable after reset", pin_oe, '0);

        // Table walk with a requirement-derived model.
        for (int v = 0; v < NV; v++) begin
            logic [W-1:0] asg, dir, od, dat, pin, per, ode;
            logic [W-1:0] e_oe, e_out, e_in, e_rd;
            {asg, dir, od, dat, pin, per} = VECS[v];
            pin_in = pin; per_out = per;
            wr(2'd0, asg); wr(2'd1, dir); wr(2'd2, od); wr(2'd3, dat);
            repeat (2) @(negedge clk);
            ode = od & 16'hFFFE;
            for (int i = 0; i < W; i++) begin
                logic ro, b, val;
                ro = (i == 0) ? 1'b0 : ((i == 1) ? 1'b1 : dir[i]);
                b = asg[i] ? ro : dir[i];
                val = asg[i] ? (ro & per[i]) : dat[i];
                e_oe[i] = b & (ode[i] ? ~val : 1'b1);
                e_out[i] = e_oe[i] & (ode[i] ? 1'b0 : val);
                e_in[i] = (asg[i] & ~ro) ? pin[i] : 1'b0;
                e_rd[i] = dir[i] ? dat[i] : pin[i];
            end
            #1;
            check("R3 R6 R7 R10 enable", pin_oe, e_oe);
            check("R3 R6 R7 R10 value", pin_out & pin_oe, e_out);
            check("R5 R9 peripheral input", per_in, e_in);
            rd(2'd3, r);
            check("R2 data readback", r, e_rd);
            rd(2'd2, r);
            check("R2 R8 open-drain readback", r, ode);
        end

        // R8: open-drain bit on receive pin ignored; GPIO output there stays push-pull.
        wr(2'd0, 16'h0000); wr(2'd1, 16'h0001); wr(2'd3, 16'h0001); wr(2'd2, 16'h0001);
        rd(2'd2, r);
        check("R8 od bit reads 0", r, 16'h0000);
        check("R8 receive pin still drives 1", {15'd0, pin_oe[0] & pin_out[0]}, 16'h0001);

        // R6: transmit pin assigned with direction 0 still drives.
        wr(2'd2, 16'h0000); wr(2'd0, 16'h0002); per_out = 16'h0002;
        #1 check("R6 tx drives despite dir 0", {14'd0, pin_oe[1], pin_out[1]}, 16'h0003);

        // R4: two-edge latency on the data readback.
        wr(2'd0, 16'h0000); wr(2'd1, 16'h0000);
        pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        bus_addr = 2'd3;
        pin_in = 16'hBEEF;
        @(negedge clk); #1;
        check("R4 not visible after one edge", bus_rdata, 16'h0000);
        @(negedge clk); #1;
        check("R4 visible after two edges", bus_rdata, 16'hBEEF);

        // R2: write to latch while input, then switch to output.
        wr(2'd3, 16'h6C6C); wr(2'd1, 16'hFFFF);
        rd(2'd3, r);
        check("R2 latch kept while input", r, 16'h6C6C);
        rd(2'd1, r);
        check("R2 direction readback", r, 16'hFFFF);

        // R1: reset again clears everything.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1 check("R1 enables cleared", pin_oe, '0);
        rd(2'd1, r);
        check("R1 direction cleared", r, '0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule